// File: doc/BRIEF.md
# Reflected CRC-32 Four-Lane Fold Engine

This block condenses a byte message into a 128-bit partial CRC remainder with carry-less (GF(2)) multiplication. It does not shift the message through a feedback register a bit or a byte at a time. The arithmetic is bit-reflected and least-significant-bit first. Two generator polynomials are available: the Ethernet CRC-32 and the Castagnoli CRC-32C. The `poly_sel` input chooses between them when a job starts.

Software or a DMA front end starts a job with a one-cycle `start` pulse. The pulse carries the seed CRC, the message length in bytes and the polynomial choice. The message then arrives as 16-byte beats over a valid/ready port. The engine keeps four 128-bit lanes in parallel. Each later 64-byte group advances every lane by a 512-bit distance. The lanes are then merged into one, and any leftover full beats are folded in at a 128-bit distance. A single fold unit, made of two 64x64 carry-less multipliers, is shared by all phases.

The engine reports the 128-bit result with a one-cycle `done` strobe. A downstream stage reduces that value to the final 32-bit CRC.

Top module: `crcfold_engine`

## Requirements
- R1: The first message byte of a beat sits in `in_data[127:120]`. The engine reverses the byte order of each beat before use, so message byte j of the beat lands in bits [8j+7:8j] of the working value.
- R2: The seed `init_crc` is zero-extended to 128 bits, with the seed in bits [31:0]. It is XORed into the first beat of a job only.
- R3: The first four beats of a job, in arrival order, load lanes 0, 1, 2 and 3.
- R4: Each later complete group of four beats updates lane i (i = 0 to 3) with its matching beat i. The new lane value is clmul(lane[127:64], KA) ^ clmul(lane[63:0], KB) ^ beat. With `poly_sel`=0 (Ethernet), KA=0x1C6E41596 and KB=0x154442BD4. With `poly_sel`=1 (Castagnoli), KA=0x09E4ADDF8 and KB=0x740EEF02.
- R5: When fewer than four full beats remain, lanes 1, 2 and 3 are merged into lane 0 in that order. Each step sets lane0 = clmul(lane0[127:64], KC) ^ clmul(lane0[63:0], KD) ^ laneN. With `poly_sel`=0, KC=0x0CCAA009E and KD=0x1751997D0. With `poly_sel`=1, KC=0x14CD00BD6 and KD=0xF20C0DFE. `in_ready` stays low for exactly the three merge cycles.
- R6: Each remaining full beat is folded into lane 0 with the KC/KD step. Exactly floor(`total_len`/16) beats are accepted. Bytes past the last full beat are never requested. `total_len` must be at least 64.
- R7: After the last step, `done` is high for exactly one cycle, with `remainder` holding lane 0. The engine then returns to idle.
- R8: While idle, `in_ready` is low and data beats have no effect. A `start` pulse during a job has no effect on that job.
- R9: `poly_sel`, `init_crc` and `total_len` are sampled only on an accepted `start`. Later changes to them do not affect the running job.
- R10: After reset, `in_ready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job when idle |
| poly_sel | input | 1 | 0 = Ethernet CRC-32, 1 = Castagnoli CRC-32C |
| init_crc | input | 32 | Seed CRC value |
| total_len | input | LEN_W (16) | Message length in bytes, at least 64 |
| in_valid | input | 1 | Data beat present |
| in_data | input | 128 | 16-byte beat, first byte in the top byte |
| in_ready | output | 1 | Engine accepts a beat this cycle |
| done | output | 1 | One-cycle completion strobe |
| remainder | output | 128 | Folded 128-bit value, valid with `done` |

## Verification
The assertions assume three things about the inputs. A start pulse arriving while idle carries a length of at least 64 bytes. The data source offers beats only as the handshake allows. Beats are counted only on cycles where `in_valid` and `in_ready` are both high. The stimulus keeps within these limits. Every listed length is 64 bytes or more. Beats are offered from a counter that advances only on an accepted handshake, with stall cycles inserted in some cases. A stray `start` in the middle of a job, and beats driven while idle, test that such inputs are ignored, not that they are illegal.

// File: rtl/crcfold_pkg.sv
package crcfold_pkg;

   localparam int BEAT_W = 128;
   localparam int HALF_W = 64;
   localparam int LANES  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BULK,
      ST_MERGE,
      ST_TAIL,
      ST_FIN
   } fold_state_t;

   // far_* advance a lane by 512 bits, near_* by 128 bits
   typedef struct packed {
      logic [HALF_W-1:0] far_hi;
      logic [HALF_W-1:0] far_lo;
      logic [HALF_W-1:0] near_hi;
      logic [HALF_W-1:0] near_lo;
   } fold_k_t;

   function automatic fold_k_t fold_consts(input logic castagnoli);
      fold_k_t k;
      if (castagnoli) begin
         k.far_hi  = 64'h0_9E4A_DDF8;
         k.far_lo  = 64'h0_740E_EF02;
         k.near_hi = 64'h1_4CD0_0BD6;
         k.near_lo = 64'h0_F20C_0DFE;
      end else begin
         k.far_hi  = 64'h1_C6E4_1596;
         k.far_lo  = 64'h1_5444_2BD4;
         k.near_hi = 64'h0_CCAA_009E;
         k.near_lo = 64'h1_7519_97D0;
      end
      return k;
   endfunction

endpackage

// File: rtl/crcfold_clmul.sv
module crcfold_clmul #(
   parameter int OP_W = 64
) (
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   output logic [2*OP_W-2:0] prod
);
   localparam int PROD_W = 2*OP_W-1;

   if (OP_W < 2) begin : g_bad_w
      $error("crcfold_clmul: OP_W must be at least 2");
   end

   logic [PROD_W-1:0] b_ext;
   assign b_ext = {{(OP_W-1){1'b0}}, op_b};

   // XOR of shifted partial products, one per set bit of op_a
   always_comb begin
      prod = '0;
      for (int i = 0; i < OP_W; i++) begin
         if (op_a[i]) prod = prod ^ (b_ext << i);
      end
   end

endmodule

// File: rtl/crcfold_fold.sv
module crcfold_fold #(
   parameter int BEAT_W = 128
) (
   input  logic [BEAT_W-1:0]   operand,
   input  logic [BEAT_W/2-1:0] k_hi,
   input  logic [BEAT_W/2-1:0] k_lo,
   output logic [BEAT_W-1:0]   folded
);
   localparam int H_W = BEAT_W/2;
   localparam int P_W = 2*H_W-1;

   if (BEAT_W % 2 != 0) begin : g_bad_w
      $error("crcfold_fold: BEAT_W must be even");
   end

   logic [P_W-1:0] p_hi, p_lo;

   crcfold_clmul #(.OP_W(H_W)) u_mul_hi (
      .op_a (operand[BEAT_W-1:H_W]),
      .op_b (k_hi),
      .prod (p_hi)
   );

   crcfold_clmul #(.OP_W(H_W)) u_mul_lo (
      .op_a (operand[H_W-1:0]),
      .op_b (k_lo),
      .prod (p_lo)
   );

   assign folded = {1'b0, p_hi ^ p_lo};

endmodule

// File: rtl/crcfold_engine.sv
module crcfold_engine
   import crcfold_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int CRC_W   = 32,
   parameter int DATA_W  = 128,
   parameter int MIN_LEN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              poly_sel,
   input  logic [CRC_W-1:0]  init_crc,
   input  logic [LEN_W-1:0]  total_len,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              done,
   output logic [DATA_W-1:0] remainder
);
   localparam int BYTES  = DATA_W/8;
   localparam int SH_W   = $clog2(BYTES);
   localparam int BC_W   = LEN_W - SH_W;
   localparam int LANE_W = $clog2(LANES);

   if (DATA_W != BEAT_W) begin : g_chk_data
      $error("crcfold_engine: DATA_W must equal the package beat width");
   end
   if (CRC_W > DATA_W) begin : g_chk_crc
      $error("crcfold_engine: CRC_W wider than a beat");
   end
   if (LEN_W <= SH_W + LANE_W) begin : g_chk_len
      $error("crcfold_engine: LEN_W too small for a four-lane job");
   end

   fold_state_t       state_q;
   logic [LANE_W-1:0] lane_q, merge_q;
   logic [BC_W-1:0]   left_q;
   logic              first_q, cast_q;
   logic [CRC_W-1:0]  init_q;
   logic [DATA_W-1:0] acc_q [LANES];
   logic [DATA_W-1:0] acc_d [LANES];

   // byte reversal: message byte j moves to bits [8j+7:8j]
   logic [DATA_W-1:0] beat_rev;
   for (genvar b = 0; b < BYTES; b++) begin : g_rev
      assign beat_rev[8*b +: 8] = in_data[DATA_W-8-8*b +: 8];
   end

   fold_k_t           k;
   logic              use_far;
   logic [DATA_W-1:0] fold_src, fold_out, seed_vec;
   logic              take;

   assign k        = fold_consts(cast_q);
   assign use_far  = (state_q == ST_BULK);
   assign fold_src = use_far ? acc_q[lane_q] : acc_q[0];
   assign seed_vec = {{(DATA_W-CRC_W){1'b0}}, init_q};

   crcfold_fold #(.BEAT_W(DATA_W)) u_fold (
      .operand (fold_src),
      .k_hi    (use_far ? k.far_hi : k.near_hi),
      .k_lo    (use_far ? k.far_lo : k.near_lo),
      .folded  (fold_out)
   );

   assign in_ready  = (state_q == ST_BULK) || (state_q == ST_TAIL);
   assign take      = in_valid && in_ready;
   assign done      = (state_q == ST_FIN);
   assign remainder = acc_q[0];

   always_comb begin
      for (int i = 0; i < LANES; i++) acc_d[i] = acc_q[i];
      unique case (state_q)
         ST_BULK: if (take) begin
            if (first_q)
               acc_d[lane_q] = beat_rev ^ ((lane_q == '0) ? seed_vec : '0);
            else
               acc_d[lane_q] = fold_out ^ beat_rev;
         end
         ST_MERGE: acc_d[0] = fold_out ^ acc_q[merge_q];
         ST_TAIL:  if (take) acc_d[0] = fold_out ^ beat_rev;
         default: ;
      endcase
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) acc_q[g] <= '0;
         else        acc_q[g] <= acc_d[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lane_q  <= '0;
         merge_q <= '0;
         left_q  <= '0;
         first_q <= 1'b0;
         cast_q  <= 1'b0;
         init_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               cast_q  <= poly_sel;
               init_q  <= init_crc;
               left_q  <= total_len[LEN_W-1:SH_W];
               lane_q  <= '0;
               first_q <= 1'b1;
               state_q <= ST_BULK;
            end
            ST_BULK: if (take) begin
               left_q <= left_q - 1'b1;
               lane_q <= lane_q + 1'b1;
               if (lane_q == LANE_W'(LANES-1)) begin
                  first_q <= 1'b0;
                  if (left_q <= BC_W'(LANES)) begin
                     state_q <= ST_MERGE;
                     merge_q <= LANE_W'(1);
                  end
               end
            end
            ST_MERGE: begin
               merge_q <= merge_q + 1'b1;
               if (merge_q == LANE_W'(LANES-1))
                  state_q <= (left_q == '0) ? ST_FIN : ST_TAIL;
            end
            ST_TAIL: if (take) begin
               left_q <= left_q - 1'b1;
               if (left_q == BC_W'(1)) state_q <= ST_FIN;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // checker-only beat accounting
   logic [BC_W-1:0] chk_total, chk_taken;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_total <= '0;
         chk_taken <= '0;
      end else if (start && state_q == ST_IDLE) begin
         chk_total <= total_len[LEN_W-1:SH_W];
         chk_taken <= '0;
      end else if (take) begin
         chk_taken <= chk_taken + 1'b1;
      end
   end

   assert_min_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q == ST_IDLE) |-> (total_len >= LEN_W'(MIN_LEN)));

   assert_no_extra_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (chk_taken < chk_total));

   assert_done_all_beats_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (chk_taken == chk_total));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !in_ready);

endmodule

// File: tb/tb_crcfold_engine.sv
module tb_crcfold_engine;

   localparam int NCASE = 6;
   localparam int WD_CYCLES = 150000;

   localparam logic [15:0] C_LEN  [NCASE] = '{16'd64, 16'd128, 16'd80, 16'd304, 16'd100, 16'd255};
   localparam logic        C_CAST [NCASE] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam logic [31:0] C_INIT [NCASE] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678,
                                              32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_A5A5};
   localparam int          C_SEED [NCASE] = '{11, 22, 33, 44, 55, 66};
   localparam logic        C_GAP  [NCASE] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         poly_sel = 1'b0;
   logic [31:0]  init_crc = '0;
   logic [15:0]  total_len = '0;
   logic         in_valid = 1'b0;
   logic [127:0] in_data = '0;
   logic         in_ready, done;
   logic [127:0] remainder;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   crcfold_engine dut (
      .clk, .rst_n, .start, .poly_sel, .init_crc, .total_len,
      .in_valid, .in_data, .in_ready, .done, .remainder
   );

   // ---------------- reference model ----------------
   function automatic logic [127:0] gen_beat(input int seed, input int k);
      logic [127:0] v;
      if (seed == 0) return '0;
      for (int w = 0; w < 4; w++)
         v[32*w +: 32] = (32'(seed) * 32'h9E37_79B9) ^ (32'(k*4 + w + 1) * 32'h85EB_CA6B);
      return v;
   endfunction

   function automatic logic [127:0] brev(input logic [127:0] x);
      logic [127:0] y;
      for (int j = 0; j < 16; j++) y[8*j +: 8] = x[127-8*j -: 8];
      return y;
   endfunction

   function automatic logic [127:0] gfmul(input logic [63:0] a, input logic [63:0] b);
      logic [127:0] p = '0;
      for (int i = 0; i < 64; i++) if (b[i]) p = p ^ ({64'b0, a} << i);
      return p;
   endfunction

   function automatic logic [127:0] step(input logic [127:0] v, input logic [63:0] kh,
                                         input logic [63:0] kl);
      return gfmul(v[127:64], kh) ^ gfmul(v[63:0], kl);
   endfunction

   function automatic logic [127:0] model(input logic [15:0] len, input logic cast,
                                          input logic [31:0] init, input int seed);
      logic [127:0] a [4];
      logic [63:0] ka, kb, kc, kd;
      int n = int'(len) / 16;
      int g = 4;
      ka = cast ? 64'h09E4ADDF8 : 64'h1C6E41596;
      kb = cast ? 64'h740EEF02  : 64'h154442BD4;
      kc = cast ? 64'h14CD00BD6 : 64'h0CCAA009E;
      kd = cast ? 64'hF20C0DFE  : 64'h1751997D0;
      for (int i = 0; i < 4; i++) a[i] = brev(gen_beat(seed, i));
      a[0] = a[0] ^ {96'b0, init};
      while (n - g >= 4) begin
         for (int i = 0; i < 4; i++) a[i] = step(a[i], ka, kb) ^ brev(gen_beat(seed, g + i));
         g += 4;
      end
      for (int i = 1; i < 4; i++) a[0] = step(a[0], kc, kd) ^ a[i];
      while (g < n) begin
         a[0] = step(a[0], kc, kd) ^ brev(gen_beat(seed, g));
         g++;
      end
      return a[0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // run one job; poke_start injects a stray start mid-job
   task automatic run_job(input logic [15:0] len, input logic cast, input logic [31:0] init,
                          input int seed, input bit gap, input bit poke_start, input string tag);
      logic [127:0] exp = model(len, cast, init, seed);
      int taken = 0;
      int low = 0;
      int cyc = 0;
      bit seen = 0;
      @(negedge clk);
      start = 1'b1; total_len = len; poly_sel = cast; init_crc = init;
      @(negedge clk);
      start = 1'b0; poly_sel = ~cast; init_crc = ~init; total_len = 16'd64;  // R9: later changes ignored
      while (!seen && cyc < 2000) begin
         if (done) begin
            seen = 1;
            check(remainder == exp, tag, "remainder", remainder, exp);
         end else begin
            bit stall = gap && (cyc % 3 == 1);
            bit fire;
            if (!in_ready) low++;
            in_valid = !stall;
            in_data  = gen_beat(seed, taken);
            start    = poke_start && (cyc == 2);
            fire     = !stall && in_ready;
            @(posedge clk);
            if (fire) taken++;
            @(negedge clk);
            start = 1'b0;
            cyc++;
         end
      end
      in_valid = 1'b0;
      check(seen, "R7", "done seen", 128'(seen), 128'd1);
      check(taken == int'(len) / 16, "R6", "beats accepted", 128'(taken), 128'(int'(len) / 16));
      check(low == 3, "R5", "ready-low merge cycles", 128'(low), 128'd3);
      @(negedge clk);
      check(!done, "R7", "done one cycle", 128'(done), 128'd0);
      check(!in_ready, "R8", "ready low after done", 128'(in_ready), 128'd0);
   endtask

   initial begin
      #(4 * WD_CYCLES);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!in_ready, "R10", "ready in reset", 128'(in_ready), 128'd0);
      check(!done, "R10", "done in reset", 128'(done), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!in_ready && !done, "R10", "outputs after reset", {in_ready, done}, 128'd0);

      // R1 R2 R3 R4 R5 R6: table of jobs
      for (int c = 0; c < NCASE; c++)
         run_job(C_LEN[c], C_CAST[c], C_INIT[c], C_SEED[c], C_GAP[c], 1'b0, "R4");

      // R8: beats while idle are ignored
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; in_data = gen_beat(99, i);
         @(negedge clk);
         check(!in_ready, "R8", "ready while idle", 128'(in_ready), 128'd0);
      end
      in_valid = 1'b0;
      run_job(16'd64, 1'b0, 32'hFFFF_FFFF, 11, 1'b0, 1'b0, "R8");

      // R8: stray start mid-job has no effect
      run_job(16'd192, 1'b1, 32'hFFFF_FFFF, 77, 1'b0, 1'b1, "R8");

      // R1 R2: zero data, zero seed gives zero; zero data with seed isolates seed placement
      run_job(16'd64, 1'b0, 32'h0, 0, 1'b0, 1'b0, "R1");
      run_job(16'd112, 1'b1, 32'hDEAD_BEEF, 0, 1'b1, 1'b0, "R2");
      run_job(16'd127, 1'b0, 32'h0BAD_F00D, 5, 1'b0, 1'b0, "R3");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule